// File: doc/BRIEF.md
# Byte Memory Bus Cycle Generator

This block is a bus master for an asynchronous, CPU-style byte memory bus with a 19-bit address, an 8-bit data path and three active-low strobes: a memory request, a read strobe and a write strobe. A client hands it one request at a time. Each request is a single-byte read, a single-byte write, or a fill that stores one byte value into a run of consecutive addresses. On completion the block pulses `done`. After a read it also presents the sampled byte on `rd_data`.

Every strobe width is a whole number of clock cycles set by a parameter. During a fill the memory request stays low from the first byte to the last. Each byte gets its own data setup period and its own write pulse, and the address steps by one between bytes. The block only owns the bus while `bus_grant` is high. The data path has separate out, output-enable and in signals, so an outer level can build the tristate pad.

Top module: `membus_engine`

## Requirements
- R1: While `rst` is high, and after it falls until a request is accepted, `mreq_n`, `rd_n` and `wr_n` are 1. `data_oe`, `data_out`, `done`, `rd_data` and `mem_addr` are all 0.
- R2: `req_ready` equals `bus_grant` while the block is idle and is 0 otherwise. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The operation codes on `req_op` are 0 = read, 1 = write, 2 = fill and 3 = no operation. `req_valid` has no effect while the block is busy or `bus_grant` is 0.
- R3: A write proceeds through these phases, one after another:
  - `mem_addr` is loaded.
  - For SETUP_CYC cycles, `mreq_n` is 0, `data_oe` is 1 and `data_out` carries the byte.
  - `wr_n` is 0 for WR_LOW_CYC cycles.
  - For one cycle `wr_n` is 1 while `mreq_n` is still 0.
  - In the final cycle `mreq_n` returns to 1 and `done` is 1.
- R4: A read proceeds through these phases:
  - One cycle with `mreq_n` at 0 and `data_oe` at 0.
  - `rd_n` is 0 for RD_LOW_CYC cycles. `data_in` is sampled at the clock edge that ends this low period and appears on `rd_data`. `rd_data` then holds until the next completed read.
  - One cycle with `rd_n` at 1 and `mreq_n` at 0.
  - One cycle with `mreq_n` at 1 and `done` at 1.
- R5: A fill of length N writes `req_data` to N consecutive addresses starting at `req_addr`. Each byte has the write phases of R3 apart from the final release. `mreq_n` stays 0 from the first setup cycle to the last byte's release cycle. The address advances by one when the next byte's setup begins.
- R6: Fill addresses wrap modulo 2^19. The address after 0x7FFFF is 0x00000.
- R7: A fill of length 0, or operation code 3, completes with `done` one cycle after acceptance. No strobe is asserted. `req_len` has no effect on reads and writes.
- R8: `data_out` is 0 whenever `data_oe` is 0, and `data_oe` is never 1 while `rd_n` is 0.
- R9: If `bus_grant` is 0 at a clock edge while the block is busy, the operation is abandoned at that edge. In the next cycle all strobes are 1, `data_oe` is 0, `done` stays 0, `rd_data` is unchanged and the block is idle.
- R10: `done` is a single-cycle pulse, issued once for each accepted request that is not abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_grant | input | 1 | High while this block owns the memory bus |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 fill, 3 no operation |
| req_addr | input | ADDR_W | Start address |
| req_data | input | DATA_W | Byte to write or fill |
| req_len | input | LEN_W | Fill byte count |
| req_ready | output | 1 | Idle and granted; request taken when valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Byte captured by the last read |
| mem_addr | output | ADDR_W | Bus address |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| data_out | output | DATA_W | Outgoing data byte |
| data_oe | output | 1 | Data driver enable |
| data_in | input | DATA_W | Incoming data byte |

## Verification
The bench drives `data_in` with a value that changes on every cycle of the read strobe. If the design sampled early, it would latch a smaller value and miss the one present at the end of the low period. Fills that cross the top of the address space expose a design that saturates or extends the address instead of wrapping. Fills that span several bytes expose a design that lets `mreq_n` bounce between bytes.

Zero-length fills and operation code 3 catch a design that issues a stray write pulse. Requests raised while busy or ungranted catch a design that restarts mid-cycle. Withdrawing the grant partway through a fill catches a design that keeps strobing, still pulses `done`, or advances the address after losing the bus.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_FILL  = 2'd2,
    OP_NONE  = 2'd3
  } mb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RISE,
    ST_END
  } mb_state_e;
endpackage

// File: rtl/mb_timer.sv
module mb_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mb_addr_gen.sv
module mb_addr_gen #(
  parameter int ADDR_W = 19,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (start) begin
      addr_q <= start_addr;
      left_q <= start_len;
    end else if (step) begin
      addr_q <= addr_q + 1'b1;
      left_q <= left_q - 1'b1;
    end
  end

  assign addr = addr_q;
  assign last = (left_q <= LEN_W'(1));

  // R5
  no_len_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> left_q > LEN_W'(1));
endmodule

// File: rtl/membus_engine.sv
module membus_engine
  import membus_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int LEN_W      = 16,
  parameter int SETUP_CYC  = 2,
  parameter int WR_LOW_CYC = 2,
  parameter int RD_LOW_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_grant,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mreq_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  input  logic [DATA_W-1:0] data_in
);
  localparam int MAXC = (SETUP_CYC > WR_LOW_CYC) ?
                        ((SETUP_CYC > RD_LOW_CYC) ? SETUP_CYC : RD_LOW_CYC) :
                        ((WR_LOW_CYC > RD_LOW_CYC) ? WR_LOW_CYC : RD_LOW_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] WR_LD    = CW'(WR_LOW_CYC - 1);
  localparam logic [CW-1:0] RD_LD    = CW'(RD_LOW_CYC - 1);

  mb_state_e         state_q, state_d;
  mb_op_e            op_q, op_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic              accept, tmr_load, tmr_exp, ag_step, ag_last, capture;
  logic [CW-1:0]     tmr_val;
  logic              mreq_n_q, rd_n_q, wr_n_q, oe_q, done_q;
  logic [DATA_W-1:0] dout_q, rd_q;

  assign req_ready = (state_q == ST_IDLE) && bus_grant;
  assign accept    = req_ready && req_valid;
  assign op_n      = accept ? mb_op_e'(req_op) : op_q;
  assign dat_n     = accept ? req_data : dat_q;

  mb_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  mb_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
    .clk(clk), .rst(rst), .start(accept), .start_addr(req_addr),
    .start_len(req_len), .step(ag_step), .addr(mem_addr), .last(ag_last)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = SETUP_LD;
    ag_step  = 1'b0;
    capture  = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (op_n == OP_READ || op_n == OP_WRITE ||
            (op_n == OP_FILL && req_len != '0)) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = (op_n == OP_READ) ? '0 : SETUP_LD;
        end else begin
          state_d = ST_END;
        end
      end
      ST_SETUP: if (tmr_exp) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = (op_q == OP_READ) ? RD_LD : WR_LD;
      end
      ST_STROBE: if (tmr_exp) begin
        state_d = ST_RISE;
        capture = (op_q == OP_READ);
      end
      ST_RISE: begin
        if (op_q == OP_FILL && !ag_last) begin
          state_d  = ST_SETUP;
          ag_step  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end else begin
          state_d = ST_END;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (!bus_grant && state_q != ST_IDLE) begin
      state_d = ST_IDLE;
      ag_step = 1'b0;
      capture = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_q     <= OP_NONE;
      dat_q    <= '0;
      mreq_n_q <= 1'b1;
      rd_n_q   <= 1'b1;
      wr_n_q   <= 1'b1;
      oe_q     <= 1'b0;
      dout_q   <= '0;
      done_q   <= 1'b0;
      rd_q     <= '0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_n;
      dat_q    <= dat_n;
      mreq_n_q <= !(state_d == ST_SETUP || state_d == ST_STROBE || state_d == ST_RISE);
      rd_n_q   <= !(state_d == ST_STROBE && op_n == OP_READ);
      wr_n_q   <= !(state_d == ST_STROBE && op_n != OP_READ);
      oe_q     <= (state_d == ST_SETUP || state_d == ST_STROBE || state_d == ST_RISE)
                  && op_n != OP_READ;
      dout_q   <= ((state_d == ST_SETUP || state_d == ST_STROBE || state_d == ST_RISE)
                  && op_n != OP_READ) ? dat_n : '0;
      done_q   <= (state_d == ST_END);
      if (capture)
        rd_q <= data_in;
    end
  end

  assign mreq_n   = mreq_n_q;
  assign rd_n     = rd_n_q;
  assign wr_n     = wr_n_q;
  assign data_oe  = oe_q;
  assign data_out = dout_q;
  assign done     = done_q;
  assign rd_data  = rd_q;

  // R3
  strobe_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !mreq_n);
  // R3
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R8
  read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !data_oe);
  // R8
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> data_out == '0);
  // R3
  wr_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_n) |-> $past(data_oe));
  // R9
  grant_loss_release_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_grant |=> (mreq_n && rd_n && wr_n && !data_oe && !done));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/tb_membus_engine.sv
module tb_membus_engine;
  localparam int AW = 19, DW = 8, LW = 16, SC = 2, WC = 2, RC = 3;

  logic clk = 1'b0, rst = 1'b1, bus_grant = 1'b0, req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0, data_in = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, done, mreq_n, rd_n, wr_n, data_oe;
  logic [DW-1:0] rd_data, data_out;
  logic [AW-1:0] mem_addr;

  always #2 clk = ~clk;

  membus_engine #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .SETUP_CYC(SC),
                  .WR_LOW_CYC(WC), .RD_LOW_CYC(RC)) dut (
    .clk(clk), .rst(rst), .bus_grant(bus_grant), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
    .req_ready(req_ready), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n), .data_out(data_out),
    .data_oe(data_oe), .data_in(data_in));

  typedef struct packed {
    logic busy; logic mreq_n; logic rd_n; logic wr_n; logic oe;
    logic [DW-1:0] dout; logic [AW-1:0] addr; logic done; logic cap;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  logic [DW-1:0] rd_exp = '0;
  int checks = 0, fails = 0, dones_seen = 0, dones_exp = 0, rd_low = 0;
  string tag = "R1";

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
  endfunction

  function automatic exp_t idle_e(input logic [AW-1:0] a);
    exp_t e = '0;
    e.mreq_n = 1; e.rd_n = 1; e.wr_n = 1; e.addr = a;
    return e;
  endfunction

  // Read data changes every strobe cycle so only the last one matches.
  always @(negedge clk) begin
    if (!rd_n) rd_low = rd_low + 1; else rd_low = 0;
    data_in = rd_n ? 8'h00 : pat(mem_addr) + DW'(rd_low);
  end

  task automatic push(input logic m, r, w, o, input logic [DW-1:0] d,
                      input logic [AW-1:0] a, input logic dn, cp);
    exp_t e;
    e.busy = 1; e.mreq_n = m; e.rd_n = r; e.wr_n = w; e.oe = o;
    e.dout = d; e.addr = a; e.done = dn; e.cap = cp;
    q.push_back(e);
  endtask

  task automatic gen(input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [LW-1:0] n);
    logic [AW-1:0] x = a;
    int cnt = (op == 2'd2) ? int'(n) : ((op == 2'd3) ? 0 : 1);
    if (op == 2'd0) begin
      push(0, 1, 1, 0, 0, x, 0, 0);
      for (int i = 0; i < RC; i++) push(0, 0, 1, 0, 0, x, 0, 0);
      push(0, 1, 1, 0, 0, x, 0, 1);
    end else begin
      for (int b = 0; b < cnt; b++) begin
        if (b != 0) x = x + 1'b1;
        for (int i = 0; i < SC; i++) push(0, 1, 1, 1, d, x, 0, 0);
        for (int i = 0; i < WC; i++) push(0, 1, 0, 1, d, x, 0, 0);
        push(0, 1, 1, 1, d, x, 0, 0);
      end
    end
    push(1, 1, 1, 0, 0, x, 1, 0);
  endtask

  task automatic tick(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [LW-1:0] n, input logic g);
    exp_t nxt;
    logic [AW+DW+DW+5:0] act, exv;
    @(negedge clk);
    act = {mreq_n, rd_n, wr_n, data_oe, data_out, mem_addr, done, rd_data, req_ready};
    exv = {cur.mreq_n, cur.rd_n, cur.wr_n, cur.oe, cur.dout, cur.addr, cur.done,
           rd_exp, (!cur.busy && bus_grant)};
    checks++;
    if (act !== exv) begin
      fails++;
      $display("FAIL %s bus state actual=%h expected=%h", tag, act, exv);
    end
    if (done) dones_seen++;
    req_valid = v; req_op = op; req_addr = a; req_data = d; req_len = n; bus_grant = g;
    if (cur.busy && !g) begin
      q.delete();
      nxt = idle_e(cur.addr);
    end else if (q.size() > 0) begin
      nxt = q.pop_front();
    end else if (!cur.busy && g && v) begin
      gen(op, a, d, n);
      nxt = q.pop_front();
    end else begin
      nxt = idle_e(cur.addr);
    end
    if (nxt.cap) rd_exp = pat(nxt.addr) + DW'(RC);
    if (nxt.done) dones_exp++;
    cur = nxt;
  endtask

  task automatic drain();
    while (cur.busy || q.size() > 0) tick(0, 0, '0, '0, '0, 1);
    tick(0, 0, '0, '0, '0, 1);
  endtask

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [LW-1:0] n);
    tick(1, op, a, d, n, 1);
    drain();
  endtask

  initial begin
    cur = idle_e('0);
    repeat (4) @(negedge clk);
    // R1: reset state while rst is high
    checks++;
    if ({mreq_n, rd_n, wr_n, data_oe, data_out, done, rd_data, mem_addr} !==
        {3'b111, 1'b0, 8'h00, 1'b0, 8'h00, 19'h0}) begin
      fails++;
      $display("FAIL R1 reset actual=%b expected=111 0 00 0 00 0", {mreq_n, rd_n, wr_n});
    end
    rst = 1'b0;
    tag = "R1"; repeat (2) tick(0, 0, '0, '0, '0, 1);
    tag = "R2"; repeat (3) tick(1, 2'd1, 19'h00777, 8'h11, '0, 0);
    tag = "R3"; send(2'd1, 19'h12345, 8'h3C, 16'd0);
    tag = "R7"; send(2'd1, 19'h00042, 8'hC3, 16'd9);
    tag = "R4"; send(2'd0, 19'h00A5F, 8'hFF, 16'd4);
    tag = "R5"; send(2'd2, 19'h00100, 8'hE7, 16'd4);
    tag = "R6"; send(2'd2, 19'h7FFFE, 8'h5A, 16'd3);
    tag = "R7"; send(2'd2, 19'h01234, 8'h99, 16'd0);
    tag = "R7"; send(2'd3, 19'h04321, 8'h99, 16'd6);
    tag = "R2";
    tick(1, 2'd1, 19'h00300, 8'h81, '0, 1);
    repeat (3) tick(1, 2'd2, 19'h05555, 8'h18, 16'd5, 1);
    drain();
    tag = "R9";
    tick(1, 2'd2, 19'h00200, 8'h66, 16'd5, 1);
    repeat (9) tick(0, 0, '0, '0, '0, 1);
    repeat (2) tick(0, 0, '0, '0, '0, 0);
    tag = "R9"; tick(1, 2'd0, 19'h00400, 8'h00, '0, 1);
    repeat (3) tick(0, 0, '0, '0, '0, 0);
    tag = "R4"; send(2'd0, 19'h7FFFF, 8'h00, 16'd0);
    tag = "R5"; tick(1, 2'd2, 19'h10000, 8'h24, 16'd2, 1);
    tick(1, 2'd0, 19'h20000, 8'h00, 16'd0, 1);
    while (cur.busy || q.size() > 0) tick(1, 2'd0, 19'h20000, 8'h00, 16'd0, 1);
    tag = "R4"; drain();
    // R10: one done per completed request
    checks++;
    if (dones_seen != dones_exp) begin
      fails++;
      $display("FAIL R10 done count actual=%0d expected=%0d", dones_seen, dones_exp);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule